// File: doc/BRIEF.md
# Cache Line Reservation Monitor

This block holds the state of a single cache line and arbitrates load-locked / store-conditional pairs issued by several hardware contexts. A context is named by a CPU number and a thread number within that CPU. The line carries a six-bit status word of permission and usage flags. The block decodes that word into readable, writable and flag outputs, and it counts accesses to the line in a saturating reference counter.

A single request port delivers one operation per clock: a plain load, a load-locked, or a store that may be marked conditional. A load-locked places a reservation for the requesting context on the line. Several contexts may hold reservations at the same time. For every store the block decides, one cycle later, whether the write may go ahead and whether a conditional store succeeded. Any store removes every reservation on the line. A separate update port replaces the status word. The update can be a fill, which brings in a new line, or a plain rewrite. A rewrite that clears the valid bit is an invalidation.

Top module: `line_resv_monitor`

## Requirements
- R1: After a synchronous reset the status word is 0, the reference count is 0, resp_valid, wr_ok and sc_ok are 0, and no context holds a reservation (a conditional store right after reset fails).
- R2: is_readable is 1 exactly when status bit 0 (valid) and bit 2 (read permission) are both 1. A line that is valid without read permission is not readable.
- R3: is_writable is 1 exactly when status bit 0 (valid) and bit 1 (write permission) are both 1.
- R4: is_valid, is_dirty, is_referenced and is_prefetched show status bits 0, 3, 4 and 5 respectively.
- R5: A load-locked (req_op=1) records a reservation for the context index cpu*THREADS_PER_CPU+thread. Repeating it from the same context has no further effect. Plain loads (req_op=0) leave reservations untouched.
- R6: A conditional store (req_op=2, req_cond=1) succeeds only if the reservation of the context with the same CPU number and the same thread number is set. On success it returns sc_ok=1 and wr_ok=1. On failure it returns sc_ok=0 and wr_ok=0, so the write is blocked.
- R7: Every store, whether plain or conditional and whether it succeeds or fails, clears all reservations on the line.
- R8: A plain store (req_op=2, req_cond=0) always returns wr_ok=1 and sc_ok=0.
- R9: A status update that clears the valid bit, and any fill (upd_fill=1), clears all reservations.
- R10: Each request accepted while the line is valid increments ref_count. The count saturates at 2^REF_W-1, and a fill clears it to 0. Requests made while the line is invalid leave it unchanged.
- R11: resp_valid, wr_ok and sc_ok are registered. They describe the store presented in the previous cycle, and they are 0 in the cycle after any non-store request or idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one operation per cycle |
| req_op | input | 2 | 0 load, 1 load-locked, 2 store, 3 none |
| req_cond | input | 1 | Store is conditional |
| req_cpu | input | CPU_W | Requesting CPU number |
| req_thread | input | THR_W | Requesting thread number within the CPU |
| upd_en | input | 1 | Replace the status word |
| upd_fill | input | 1 | Update is a new-line fill |
| upd_status | input | 6 | New status word |
| status_q | output | 6 | Current status word |
| is_valid | output | 1 | Valid flag |
| is_readable | output | 1 | Valid and read permission |
| is_writable | output | 1 | Valid and write permission |
| is_dirty | output | 1 | Dirty flag |
| is_referenced | output | 1 | Referenced flag |
| is_prefetched | output | 1 | Prefetched, not yet accessed |
| resp_valid | output | 1 | Store response valid |
| wr_ok | output | 1 | Store may write |
| sc_ok | output | 1 | Conditional store succeeded |
| ref_count | output | REF_W | Saturating access counter |

## Verification
The assertions assume at most one operation per cycle. They also assume that req_thread stays below THREADS_PER_CPU and req_cpu below NUM_CPUS, so that every context index names a real reservation bit. The stimulus keeps status updates and requests in separate cycles and only uses legal CPU and thread numbers. As a result, the ordering between a reservation set and a clear in the same cycle is never exercised. Each reservation-clearing event is followed by a conditional store that would otherwise have succeeded.

// File: rtl/line_resv_pkg.sv
package line_resv_pkg;
  localparam int STAT_W = 6;
  localparam int B_VALID = 0;
  localparam int B_WPERM = 1;
  localparam int B_RPERM = 2;
  localparam int B_DIRTY = 3;
  localparam int B_REF   = 4;
  localparam int B_PREF  = 5;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_LL    = 2'd1,
    OP_STORE = 2'd2,
    OP_NONE  = 2'd3
  } line_op_e;
endpackage

// File: rtl/line_status_reg.sv
module line_status_reg
  import line_resv_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              upd_en,
  input  logic [STAT_W-1:0] upd_status,
  output logic [STAT_W-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (rst)         status_q <= '0;
    else if (upd_en) status_q <= upd_status;
  end

  p_status_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !upd_en |=> $stable(status_q));
endmodule

// File: rtl/resv_tracker.sv
module resv_tracker #(
  parameter int NUM_CTX = 8,
  parameter int CTX_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ll_en,
  input  logic             st_en,
  input  logic             clr_all,
  input  logic [CTX_W-1:0] ctx_idx,
  output logic             hit
);
  logic [NUM_CTX-1:0] resv_q;
  logic [NUM_CTX-1:0] sel;

  for (genvar i = 0; i < NUM_CTX; i++) begin : g_ctx
    assign sel[i] = (ctx_idx == CTX_W'(i));
    always_ff @(posedge clk) begin
      if (rst || clr_all || st_en) resv_q[i] <= 1'b0;
      else if (ll_en && sel[i])    resv_q[i] <= 1'b1;
    end
  end

  assign hit = |(resv_q & sel);

  p_store_clears_r7: assert property (@(posedge clk) disable iff (rst)
    st_en |=> (resv_q == '0));
  p_invalidate_clears_r9: assert property (@(posedge clk) disable iff (rst)
    clr_all |=> (resv_q == '0));
  p_ll_records_r5: assert property (@(posedge clk) disable iff (rst)
    (ll_en && !st_en && !clr_all) |=> ($countones(resv_q) >= 1));
  p_sel_onehot_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));
endmodule

// File: rtl/ref_counter.sv
module ref_counter #(
  parameter int REF_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             clr,
  output logic [REF_W-1:0] cnt
);
  localparam logic [REF_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)                  cnt <= '0;
    else if (inc && cnt != CNT_MAX)  cnt <= cnt + 1'b1;
  end

  p_saturate_r10: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_MAX && !clr) |=> (cnt == CNT_MAX));
  p_fill_zero_r10: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!inc && !clr) |=> $stable(cnt));
endmodule

// File: rtl/line_resv_monitor.sv
module line_resv_monitor
  import line_resv_pkg::*;
#(
  parameter int NUM_CPUS        = 4,
  parameter int THREADS_PER_CPU = 2,
  parameter int REF_W           = 4,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1,
  localparam int THR_W   = (THREADS_PER_CPU > 1) ? $clog2(THREADS_PER_CPU) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic              req_cond,
  input  logic [CPU_W-1:0]  req_cpu,
  input  logic [THR_W-1:0]  req_thread,
  input  logic              upd_en,
  input  logic              upd_fill,
  input  logic [STAT_W-1:0] upd_status,
  output logic [STAT_W-1:0] status_q,
  output logic              is_valid,
  output logic              is_readable,
  output logic              is_writable,
  output logic              is_dirty,
  output logic              is_referenced,
  output logic              is_prefetched,
  output logic              resp_valid,
  output logic              wr_ok,
  output logic              sc_ok,
  output logic [REF_W-1:0]  ref_count
);
  localparam int NUM_CTX = NUM_CPUS * THREADS_PER_CPU;
  localparam int CTX_W   = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1;

  logic             is_store, is_ll, clr_resv, resv_hit;
  logic [CTX_W-1:0] ctx_idx;

  assign is_store = req_valid && (req_op == OP_STORE);
  assign is_ll    = req_valid && (req_op == OP_LL);
  assign clr_resv = upd_en && (upd_fill || !upd_status[B_VALID]);
  assign ctx_idx  = CTX_W'(req_cpu) * CTX_W'(THREADS_PER_CPU) + CTX_W'(req_thread);

  line_status_reg u_status (
    .clk(clk), .rst(rst), .upd_en(upd_en), .upd_status(upd_status), .status_q(status_q)
  );

  resv_tracker #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_resv (
    .clk(clk), .rst(rst), .ll_en(is_ll), .st_en(is_store), .clr_all(clr_resv),
    .ctx_idx(ctx_idx), .hit(resv_hit)
  );

  ref_counter #(.REF_W(REF_W)) u_refcnt (
    .clk(clk), .rst(rst), .inc(req_valid && status_q[B_VALID]),
    .clr(upd_en && upd_fill), .cnt(ref_count)
  );

  assign is_valid      = status_q[B_VALID];
  assign is_readable   = status_q[B_VALID] && status_q[B_RPERM];
  assign is_writable   = status_q[B_VALID] && status_q[B_WPERM];
  assign is_dirty      = status_q[B_DIRTY];
  assign is_referenced = status_q[B_REF];
  assign is_prefetched = status_q[B_PREF];

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      wr_ok      <= 1'b0;
      sc_ok      <= 1'b0;
    end else begin
      resp_valid <= is_store;
      wr_ok      <= is_store && (!req_cond || resv_hit);
      sc_ok      <= is_store && req_cond && resv_hit;
    end
  end

  p_sc_implies_wr_r6: assert property (@(posedge clk) disable iff (rst)
    sc_ok |-> (wr_ok && resp_valid));
  p_plain_store_r8: assert property (@(posedge clk) disable iff (rst)
    (is_store && !req_cond) |=> (resp_valid && wr_ok && !sc_ok));
  p_no_resp_r11: assert property (@(posedge clk) disable iff (rst)
    !is_store |=> (!resp_valid && !wr_ok && !sc_ok));
  p_perm_need_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (is_readable || is_writable) |-> is_valid);
endmodule

// File: tb/tb_line_resv_monitor.sv
`timescale 1ns/1ps
module tb_line_resv_monitor;
  logic       clk = 1'b0;
  logic       rst;
  logic       req_valid, req_cond, upd_en, upd_fill;
  logic [1:0] req_op;
  logic [1:0] req_cpu;
  logic [0:0] req_thread;
  logic [5:0] upd_status, status_q;
  logic       is_valid, is_readable, is_writable, is_dirty, is_referenced, is_prefetched;
  logic       resp_valid, wr_ok, sc_ok;
  logic [3:0] ref_count;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  line_resv_monitor dut (.*);

  // vector: op[8:7] cond[6] cpu[5:4] thr[3] resp[2] wr[1] sc[0]
  localparam int NV = 17;
  localparam logic [8:0] VEC [NV] = '{
    {2'd1,1'b0,2'd1,1'b0,3'b000},  // R5 LL c1t0
    {2'd1,1'b0,2'd1,1'b0,3'b000},  // R5 repeat
    {2'd2,1'b1,2'd1,1'b0,3'b111},  // R6 SC success
    {2'd2,1'b1,2'd1,1'b0,3'b100},  // R7 cleared by SC
    {2'd1,1'b0,2'd2,1'b1,3'b000},  // LL c2t1
    {2'd2,1'b1,2'd2,1'b0,3'b100},  // R6 thread mismatch
    {2'd2,1'b1,2'd2,1'b1,3'b100},  // R7 cleared by failed SC
    {2'd1,1'b0,2'd3,1'b1,3'b000},  // LL c3t1
    {2'd2,1'b1,2'd1,1'b1,3'b100},  // R6 cpu mismatch
    {2'd1,1'b0,2'd0,1'b0,3'b000},  // LL c0t0
    {2'd1,1'b0,2'd3,1'b0,3'b000},  // LL c3t0
    {2'd2,1'b0,2'd2,1'b0,3'b110},  // R8 plain store
    {2'd2,1'b1,2'd0,1'b0,3'b100},  // R7 cleared by plain
    {2'd2,1'b1,2'd3,1'b0,3'b100},  // R7
    {2'd1,1'b0,2'd0,1'b1,3'b000},  // LL c0t1
    {2'd0,1'b0,2'd0,1'b1,3'b000},  // R5 load keeps resv
    {2'd2,1'b1,2'd0,1'b1,3'b111}   // R6 success
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] op, input logic cond, input logic [1:0] cpu, input logic thr);
    req_valid = 1'b1; req_op = op; req_cond = cond; req_cpu = cpu; req_thread = thr;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd3; req_cond = 1'b0;
  endtask

  task automatic set_status(input logic [5:0] v, input logic fill);
    upd_en = 1'b1; upd_status = v; upd_fill = fill;
    @(negedge clk);
    upd_en = 1'b0; upd_fill = 1'b0;
  endtask

  initial begin
    #100000;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 0; req_op = 2'd3; req_cond = 0; req_cpu = 0; req_thread = 0;
    upd_en = 0; upd_fill = 0; upd_status = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk("R1 status", status_q, 0);
    chk("R1 ref", ref_count, 0);
    chk("R1 resp", {resp_valid, wr_ok, sc_ok}, 0);
    do_req(2'd2, 1'b1, 2'd0, 1'b0);
    chk("R1 empty resv", {resp_valid, wr_ok, sc_ok}, 3'b100);

    set_status(6'h05, 1'b0);
    chk("R2 readable", {is_readable, is_writable}, 2'b10);
    set_status(6'h04, 1'b0);
    chk("R2 not valid", {is_readable, is_writable}, 2'b00);
    set_status(6'h03, 1'b0);
    chk("R3 writable", {is_readable, is_writable}, 2'b01);
    set_status(6'h02, 1'b0);
    chk("R3 not valid", is_writable, 0);
    set_status(6'h38, 1'b0);
    chk("R4 flags", {is_prefetched, is_referenced, is_dirty, is_valid}, 4'b1110);
    set_status(6'h11, 1'b0);
    chk("R4 flags2", {is_prefetched, is_referenced, is_dirty, is_valid}, 4'b0101);

    set_status(6'h07, 1'b1);
    chk("R10 fill clears", ref_count, 0);
    req_op = 2'd3;
    for (int i = 0; i < NV; i++) begin
      req_valid = 1'b1; req_op = VEC[i][8:7]; req_cond = VEC[i][6];
      req_cpu = VEC[i][5:4]; req_thread = VEC[i][3];
      @(negedge clk);
      chk($sformatf("R11 vec %0d", i), {resp_valid, wr_ok, sc_ok}, VEC[i][2:0]);
    end
    req_valid = 1'b0; req_op = 2'd3; req_cond = 1'b0;
    chk("R10 saturate", ref_count, 15);

    do_req(2'd1, 1'b0, 2'd1, 1'b0);
    set_status(6'h06, 1'b0);
    set_status(6'h07, 1'b0);
    do_req(2'd2, 1'b1, 2'd1, 1'b0);
    chk("R9 invalidate clears", {resp_valid, wr_ok, sc_ok}, 3'b100);

    do_req(2'd1, 1'b0, 2'd2, 1'b0);
    set_status(6'h07, 1'b1);
    chk("R10 fill zero", ref_count, 0);
    do_req(2'd2, 1'b1, 2'd2, 1'b0);
    chk("R9 fill clears", {resp_valid, wr_ok, sc_ok}, 3'b100);
    chk("R10 count one", ref_count, 1);
    set_status(6'h00, 1'b0);
    do_req(2'd0, 1'b0, 2'd0, 1'b0);
    chk("R10 invalid no count", ref_count, 1);
    chk("R11 load no resp", resp_valid, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule